// File: doc/BRIEF.md
# Local-History Next-Fetch Predictor

This block sits at the head of a fetch pipeline that reads two 128-bit bundles at a time, so each fetch covers 32 bytes. It keeps the current fetch address in a register and chooses the next one every cycle. On a predicted-taken branch it moves straight to that branch's target with no lost cycle. To do this it uses a direct-mapped branch data table, indexed by the fetch address. Each entry holds a tag, a stored target address and a 4-bit record of that branch's last outcomes. The record selects one 2-bit saturating counter in a shared counter table, and the counter's upper bit gives the direction.

Because the target is stored in the entry, no adder sits in the taken path. A miss or a not-taken prediction steps the fetch address forward by one bundle pair. A redirect from the execution back end wins over any prediction. A separate training port reports resolved branches, which updates the outcome record and the counter or creates a new entry.

Top module: `lhp_top`

## Requirements
- R1: After reset the fetch address equals the parameter `RESET_ADDR`. Every table entry is invalid, so the first lookups miss.
- R2: When the lookup misses and no redirect is present, the next fetch address is the current address plus 0x20.
- R3: When the lookup hits and the selected counter has bit 1 set, the next fetch address is the entry's stored target. It is loaded in the very next cycle, and `pred_taken` is 1.
- R4: When the lookup hits and the selected counter has bit 1 clear, `pred_taken` is 0 and the next fetch address is the current address plus 0x20.
- R5: An asserted redirect makes the next fetch address equal to the redirect address, whatever the table predicts.
- R6: A training event that hits its entry shifts the outcome into bit 0 of the 4-bit record, dropping the oldest bit from bit 3. A taken outcome also replaces the stored target.
- R7: A training event that hits updates the counter at the index given by the record as it was before the shift. The counter counts up on taken and down on not taken, and stays at 3 and 0.
- R8: A taken training event that misses claims its entry, with a record of 0000 and the resolved target. A not-taken miss changes nothing.
- R9: After reset every counter holds 01, so a freshly claimed entry predicts not taken.
- R10: The entry index is fetch address bits [10:5] and the tag is bits [31:11]. Two addresses with the same index and different tags do not hit each other's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Back-end redirect request |
| redir_pc | input | 32 | Redirect fetch address |
| upd_valid | input | 1 | Resolved-branch training event |
| upd_pc | input | 32 | Fetch address of the resolved branch's bundle pair |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target address |
| fetch_pc | output | 32 | Current fetch address |
| next_pc | output | 32 | Address that will be fetched next cycle |
| pred_taken | output | 1 | Lookup hit and predicts taken |
| pred_hit | output | 1 | Lookup hit a valid entry with a matching tag |

## Verification
A wrong outcome record, counter or stored target does not show up when it is written. It shows up only the next time the same bundle pair is fetched. At that point `pred_taken` and `next_pc` give the wrong direction or target in that same cycle, and `fetch_pc` follows one cycle later. The bench therefore keeps a shadow of every entry and every counter and compares all three outputs on every cycle. The stimulus is a small set of addresses that alias by index, so that trained entries are looked up again soon after each update.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  localparam logic [1:0] CTR_WEAK_NT = 2'b01;

  // saturating 2-bit up/down step
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
    logic [1:0] res;
    if (up) res = (cur == 2'b11) ? cur : cur + 2'd1;
    else    res = (cur == 2'b00) ? cur : cur - 2'd1;
    return res;
  endfunction

endpackage

// File: rtl/lhp_bdt.sv
module lhp_bdt #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 5,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [HIST_W-1:0] lk_hist,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  output logic              upd_hit,
  output logic [HIST_W-1:0] upd_old_hist
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_LO  = OFF_W + IDX_W;
  localparam int TAG_W   = ADDR_W - TAG_LO;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [HIST_W-1:0]  hist_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q  [ENTRIES];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             alloc;

  assign lk_idx = lk_pc[OFF_W +: IDX_W];
  assign lk_tag = lk_pc[ADDR_W-1:TAG_LO];
  assign up_idx = upd_pc[OFF_W +: IDX_W];
  assign up_tag = upd_pc[ADDR_W-1:TAG_LO];

  assign lk_hit       = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_hist      = hist_q[lk_idx];
  assign lk_target    = tgt_q[lk_idx];
  assign upd_hit      = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
  assign upd_old_hist = hist_q[up_idx];
  assign alloc        = upd_valid && !upd_hit && upd_taken;

  // per-entry valid flops
  for (genvar e = 0; e < ENTRIES; e++) begin : g_valid
    always_ff @(posedge clk) begin
      if (!rst_n)                           valid_q[e] <= 1'b0;
      else if (alloc && up_idx == IDX_W'(e)) valid_q[e] <= 1'b1;
    end
  end

  // entry payload, qualified by valid so no reset needed
  always_ff @(posedge clk) begin
    if (upd_valid) begin
      if (upd_hit) begin
        hist_q[up_idx] <= {upd_old_hist[HIST_W-2:0], upd_taken};
        if (upd_taken) tgt_q[up_idx] <= upd_target;
      end else if (upd_taken) begin
        tag_q[up_idx]  <= up_tag;
        hist_q[up_idx] <= '0;
        tgt_q[up_idx]  <= upd_target;
      end
    end
  end

endmodule

// File: rtl/lhp_pht.sv
module lhp_pht #(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output logic [1:0]        rd_ctr,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_up
);
  import lhp_pkg::*;
  localparam int DEPTH = 1 << HIST_W;

  logic [1:0] ctr_q [DEPTH];

  assign rd_ctr = ctr_q[rd_idx];

  for (genvar c = 0; c < DEPTH; c++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rst_n)                          ctr_q[c] <= CTR_WEAK_NT;
      else if (wr_en && wr_idx == HIST_W'(c)) ctr_q[c] <= ctr_step(ctr_q[c], wr_up);
    end
  end

endmodule

// File: rtl/lhp_nextpc.sv
module lhp_nextpc #(
  parameter int                ADDR_W     = 32,
  parameter int                OFF_W      = 5,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_pc,
  input  logic              lk_hit,
  input  logic              ctr_msb,
  input  logic [ADDR_W-1:0] lk_target,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] next_pc,
  output logic              pred_taken
);
  localparam logic [ADDR_W-1:0] PAIR_BYTES = ADDR_W'(1) << OFF_W;

  function automatic logic [ADDR_W-1:0] seq_of(input logic [ADDR_W-1:0] pc);
    return pc + PAIR_BYTES;
  endfunction

  logic [ADDR_W-1:0] pc_q;

  assign pred_taken = lk_hit && ctr_msb;
  assign next_pc    = redir_valid ? redir_pc :
                      pred_taken  ? lk_target : seq_of(pc_q);
  assign fetch_pc   = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_ADDR;
    else        pc_q <= next_pc;
  end

endmodule

// File: rtl/lhp_top.sv
module lhp_top #(
  parameter int                ADDR_W     = 32,
  parameter int                IDX_W      = 6,
  parameter int                OFF_W      = 5,
  parameter int                HIST_W     = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_pc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] next_pc,
  output logic              pred_taken,
  output logic              pred_hit
);
  // named internal events
  logic              lk_hit;
  logic [HIST_W-1:0] lk_hist;
  logic [ADDR_W-1:0] lk_target;
  logic [1:0]        lk_ctr;
  logic              upd_hit;
  logic [HIST_W-1:0] upd_old_hist;
  logic              pht_wr;

  assign pht_wr   = upd_valid && upd_hit;
  assign pred_hit = lk_hit;

  lhp_bdt #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .HIST_W(HIST_W)) u_bdt (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(fetch_pc), .lk_hit(lk_hit), .lk_hist(lk_hist), .lk_target(lk_target),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_hit(upd_hit), .upd_old_hist(upd_old_hist)
  );

  lhp_pht #(.HIST_W(HIST_W)) u_pht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_hist), .rd_ctr(lk_ctr),
    .wr_en(pht_wr), .wr_idx(upd_old_hist), .wr_up(upd_taken)
  );

  lhp_nextpc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .RESET_ADDR(RESET_ADDR)) u_npc (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_pc(redir_pc),
    .lk_hit(lk_hit), .ctr_msb(lk_ctr[1]), .lk_target(lk_target),
    .fetch_pc(fetch_pc), .next_pc(next_pc), .pred_taken(pred_taken)
  );

endmodule

// File: rtl/lhp_chk.sv
module lhp_chk #(
  parameter int                ADDR_W     = 32,
  parameter int                OFF_W      = 5,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_pc,
  input logic              lk_hit,
  input logic [1:0]        lk_ctr,
  input logic [ADDR_W-1:0] lk_target,
  input logic [ADDR_W-1:0] fetch_pc
);
  logic first_q;
  always_ff @(posedge clk) first_q <= !rst_n;

  a_r1_reset_addr: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |-> fetch_pc == RESET_ADDR);

  a_r5_redirect_wins: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> fetch_pc == $past(redir_pc));

  a_r3_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && lk_hit && lk_ctr[1]) |=> fetch_pc == $past(lk_target));

  a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && !(lk_hit && lk_ctr[1])) |=>
      fetch_pc == $past(fetch_pc) + (ADDR_W'(1) << OFF_W));

endmodule

bind lhp_top lhp_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .RESET_ADDR(RESET_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
  .lk_hit(lk_hit), .lk_ctr(lk_ctr), .lk_target(lk_target), .fetch_pc(fetch_pc)
);

// File: tb/lhp_top_tb.sv
module lhp_top_tb;
  localparam logic [31:0] RST_A = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        redir_valid, upd_valid, upd_taken;
  logic [31:0] redir_pc, upd_pc, upd_target;
  logic [31:0] fetch_pc, next_pc;
  logic        pred_taken, pred_hit;

  always #5 clk = ~clk;

  lhp_top #(.RESET_ADDR(RST_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .pred_taken(pred_taken), .pred_hit(pred_hit)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // shadow model
  bit          m_v   [64];
  int unsigned m_tag [64];
  int unsigned m_h   [64];
  logic [31:0] m_tgt [64];
  int unsigned m_pht [16];
  logic [31:0] m_pc;

  function automatic int unsigned slot(logic [31:0] a); return (a / 32) % 64; endfunction
  function automatic int unsigned tagv(logic [31:0] a); return a / 2048; endfunction
  function automatic bit looks_hit(logic [31:0] a);
    return m_v[slot(a)] && m_tag[slot(a)] == tagv(a);
  endfunction
  function automatic int unsigned sat(int unsigned c, bit up);
    if (up) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction
  function automatic logic [31:0] pick(int k);
    return 32'h0000_4000 + 32'((k % 4) * 32) + 32'((k / 4) * 2048);
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive, check combinational/registered outputs, advance model
  task automatic step(bit rv, logic [31:0] rpc, bit uv, logic [31:0] upc,
                      bit ut, logic [31:0] utg, string tag);
    bit          h, t;
    logic [31:0] exp_n;
    int unsigned i;
    redir_valid = rv; redir_pc = rpc;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
    #1;
    h = looks_hit(m_pc);
    t = h && (m_pht[m_h[slot(m_pc)]] >= 2);
    exp_n = rv ? rpc : (t ? m_tgt[slot(m_pc)] : m_pc + 32'h20);
    if (tag == "") tag = rv ? "R5" : (!h ? "R2" : (t ? "R3" : "R4"));
    cmp({tag, " fetch_pc"}, fetch_pc, m_pc);
    cmp({tag, " pred_hit"}, 32'(pred_hit), 32'(h));
    cmp({tag, " pred_taken"}, 32'(pred_taken), 32'(t));
    cmp({tag, " next_pc"}, next_pc, exp_n);
    if (uv) begin
      i = slot(upc);
      if (looks_hit(upc)) begin
        m_pht[m_h[i]] = sat(m_pht[m_h[i]], ut);
        m_h[i] = (m_h[i] * 2 + 32'(ut)) % 16;
        if (ut) m_tgt[i] = utg;
      end else if (ut) begin
        m_v[i] = 1; m_tag[i] = tagv(upc); m_h[i] = 0; m_tgt[i] = utg;
      end
    end
    m_pc = exp_n;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] pa, pb, q;
    void'($urandom(32'd1234));
    rst_n = 0; redir_valid = 0; redir_pc = 0; upd_valid = 0;
    upd_pc = 0; upd_taken = 0; upd_target = 0;
    for (int k = 0; k < 64; k++) begin m_v[k] = 0; m_h[k] = 0; m_tag[k] = 0; m_tgt[k] = 0; end
    for (int k = 0; k < 16; k++) m_pht[k] = 1;
    m_pc = RST_A;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    cmp("R1 reset fetch_pc", fetch_pc, RST_A);
    cmp("R1 reset miss", 32'(pred_hit), 32'd0);
    @(negedge clk);
    m_pc = RST_A + 32'h20;

    pa = 32'h0000_2040; pb = pa + 32'h800; q = 32'h0000_3060;
    // R8 allocation on a taken miss; R9 weak not-taken counters
    step(1, pa, 1, pa, 1, 32'h0000_9000, "R8");
    step(1, pa, 0, 0, 0, 0, "R9");
    // R6/R7 train taken until saturated, then a not-taken
    for (int k = 0; k < 9; k++) step(1, pa, 1, pa, 1, 32'h0000_9000, "R7");
    step(1, pa, 1, pa, 0, 0, "R6");
    for (int k = 0; k < 3; k++) step(1, pa, 1, pa, 1, 32'h0000_A000, "R6");
    step(0, 0, 0, 0, 0, 0, "");
    // down-saturation at 0
    step(1, pa, 0, 0, 0, 0, "");
    for (int k = 0; k < 8; k++) step(1, pa, 1, pa, 0, 0, "R7");
    step(1, pa, 1, pa, 1, 32'h0000_9000, "R7");
    // R10 aliasing: same index, other tag
    step(1, pa, 1, pb, 1, 32'h0000_B000, "R10");
    step(1, pa, 0, 0, 0, 0, "R10");
    // R8 not-taken miss does not claim
    step(1, q, 1, q, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R8");

    for (int n = 0; n < 4000; n++) begin
      bit rv, uv, ut;
      rv = ($urandom % 100) < 15;
      uv = ($urandom % 100) < 60;
      ut = ($urandom % 100) < 65;
      step(rv, pick($urandom % 8), uv, pick($urandom % 8), ut,
           pick($urandom % 8), "");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule